// File: doc/BRIEF.md
# Iterative XOR-AND-Shift Adder

This block adds two unsigned N-bit words by repeated rewriting instead of a carry chain. The first step merges the two addends into a partial-sum word, formed by XOR, and a carry word, formed by AND and then moved one place to the left. After that, each clock cycle merges the two words again in the same way. The loop stops in the first cycle in which the carry word holds no set bit. The partial-sum word is then the final sum. It is presented on an (N+1)-bit result port, and the top bit of that port is the carry-out. A one-cycle done pulse marks the completion.

The number of cycles depends on the data. Addends with no common set bit finish with zero extra steps. The longest carry chain needs N steps. The block also reports how many extra steps the current sum took, so a caller can see the cost of each addition.

A three-state machine sequences the work. ST_IDLE waits for start; the transition T_LAUNCH on start moves it to ST_RUN. ST_RUN repeats one merge step per cycle. Its transition T_RETIRE goes to ST_DONE when the carry word is clear or the step count has reached N. ST_DONE lasts one cycle, with done high. From ST_DONE, T_RELAUNCH goes straight back to ST_RUN if start is high, and T_REST goes to ST_IDLE otherwise.

Top module: `xas_adder`

## Requirements
- R1: A synchronous active-high reset clears busy, done, the step count and the result to zero.
- R2: When start is high in a cycle where busy is low, the addends are captured at that clock edge. Busy is high from the next cycle on, until the computation ends.
- R3: Every step replaces the partial-sum word with the XOR of the two words, and the carry word with their AND shifted left by one bit. The arithmetic sum of the two words therefore never changes while busy. No set carry bit is ever lost above bit N.
- R4: Iteration stops when the carry word is all zeros. Done is then high for exactly one cycle, busy is low in that cycle, and the result equals addend_a + addend_b, with bit N holding the carry-out.
- R5: The step count is the number of merge steps after the first one. It is 0 when the addends share no set bit, it never exceeds N, and for the addends (2^k - 1) and 1 it equals k.
- R6: Done appears exactly steps+1 cycles after the clock edge that captured start.
- R7: While busy is high, start and any change on the addends have no effect on the result or the step count of the running computation.
- R8: The result and the step count keep their values after done until the next accepted start. The result keeps its old value through a new computation until that computation completes.
- R9: The block computes correct sums at the width given by the width parameter, at 4 bits and at other widths.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Request a new addition; accepted only while busy is low |
| addend_a | input | WIDTH | First unsigned addend |
| addend_b | input | WIDTH | Second unsigned addend |
| result | output | WIDTH+1 | Sum, with the carry-out in the top bit |
| busy | output | 1 | High while merge steps are in progress |
| done | output | 1 | One-cycle pulse marking a valid result |
| steps | output | clog2(WIDTH+1) | Merge steps taken after the first one |

## Verification
The 4-bit instance is driven with every one of the 256 addend pairs. That separates correct carry handling from cases that pass only when no carries arise, and it shows that the step count stays within 4 and matches the latency. An 8-bit instance runs a table of chosen pairs. Disjoint bit patterns must finish with zero steps, and all-ones plus one must walk the full chain of N steps. Equal high bits must produce the carry-out, and mixed patterns must give intermediate counts. Directed runs then change start and the addends during a computation, and watch the result after completion, to show that the running sum is isolated and the outputs hold.

// File: rtl/xas_pkg.sv
package xas_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RUN  = 2'd1,
        ST_DONE = 2'd2
    } xas_state_e;

endpackage

// File: rtl/xas_step.sv
module xas_step #(
    parameter int W = 5
) (
    input  logic [W-1:0] x_i,
    input  logic [W-1:0] y_i,
    output logic [W-1:0] sum_o,
    output logic [W-1:0] carry_o,
    output logic         spill_o
);

    // one merge step: per-bit XOR for the partial sum, AND moved up one place
    for (genvar i = 0; i < W; i++) begin : g_bit
        assign sum_o[i] = x_i[i] ^ y_i[i];
        if (i == 0) begin : g_lsb
            assign carry_o[i] = 1'b0;
        end else begin : g_upper
            assign carry_o[i] = x_i[i-1] & y_i[i-1];
        end
    end

    // a carry generated in the top bit would leave the word
    assign spill_o = x_i[W-1] & y_i[W-1];

endmodule

// File: rtl/xas_ctrl.sv
module xas_ctrl
    import xas_pkg::*;
#(
    parameter int N  = 4,
    parameter int CW = 3
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          start_i,
    input  logic          carry_zero_i,
    output logic          load_o,
    output logic          step_o,
    output logic          finish_o,
    output logic          busy_o,
    output logic          done_o,
    output logic [CW-1:0] steps_o
);

    localparam logic [CW-1:0] STEP_LIMIT = CW'(N);

    xas_state_e    state_q, state_d;
    logic [CW-1:0] steps_q;
    logic          at_limit;

    assign at_limit = (steps_q == STEP_LIMIT);

    // state register
    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // transitions T_LAUNCH, T_RETIRE, T_RELAUNCH, T_REST
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (start_i) state_d = ST_RUN;
            ST_RUN:  if (carry_zero_i || at_limit) state_d = ST_DONE;
            ST_DONE: state_d = start_i ? ST_RUN : ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    // outputs decoded from the state
    always_comb begin
        load_o   = 1'b0;
        step_o   = 1'b0;
        finish_o = 1'b0;
        busy_o   = 1'b0;
        done_o   = 1'b0;
        unique case (state_q)
            ST_IDLE: load_o = start_i;
            ST_RUN: begin
                busy_o   = 1'b1;
                finish_o = carry_zero_i || at_limit;
                step_o   = !(carry_zero_i || at_limit);
            end
            ST_DONE: begin
                done_o = 1'b1;
                load_o = start_i;
            end
            default: ;
        endcase
    end

    // step counter
    always_ff @(posedge clk) begin
        if (rst || load_o) begin
            steps_q <= '0;
        end else if (step_o) begin
            steps_q <= steps_q + 1'b1;
        end
    end

    assign steps_o = steps_q;

    assert_step_bound_R5: assert property (@(posedge clk) disable iff (rst)
        steps_q <= STEP_LIMIT);

    assert_done_single_R4: assert property (@(posedge clk) disable iff (rst)
        done_o |=> !done_o);

    assert_done_not_busy_R4: assert property (@(posedge clk) disable iff (rst)
        !(done_o && busy_o));

    assert_launch_busy_R2: assert property (@(posedge clk) disable iff (rst)
        (start_i && !busy_o) |=> busy_o);

    assert_count_frozen_R8: assert property (@(posedge clk) disable iff (rst)
        (!busy_o && !load_o && !$past(load_o)) |-> $stable(steps_q));

endmodule

// File: rtl/xas_datapath.sv
module xas_datapath #(
    parameter int N = 4
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load_i,
    input  logic         step_i,
    input  logic         finish_i,
    input  logic         done_i,
    input  logic [N-1:0] a_i,
    input  logic [N-1:0] b_i,
    output logic         carry_zero_o,
    output logic [N:0]   result_o
);

    localparam int RW = N + 1;

    logic [RW-1:0] sum_q, carry_q, result_q;
    logic [RW-1:0] op_x, op_y, nxt_sum, nxt_carry;
    logic          spill;

    // on load the first merge uses the addends, afterwards the held words
    assign op_x = load_i ? {1'b0, a_i} : sum_q;
    assign op_y = load_i ? {1'b0, b_i} : carry_q;

    xas_step #(.W(RW)) u_step (
        .x_i     (op_x),
        .y_i     (op_y),
        .sum_o   (nxt_sum),
        .carry_o (nxt_carry),
        .spill_o (spill)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            sum_q   <= '0;
            carry_q <= '0;
        end else if (load_i || step_i) begin
            sum_q   <= nxt_sum;
            carry_q <= nxt_carry;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            result_q <= '0;
        end else if (finish_i) begin
            result_q <= sum_q;
        end
    end

    assign carry_zero_o = (carry_q == '0);
    assign result_o     = result_q;

    assert_sum_preserved_R3: assert property (@(posedge clk) disable iff (rst)
        $past(step_i) |-> ({1'b0, sum_q} + {1'b0, carry_q}) ==
                          $past({1'b0, sum_q} + {1'b0, carry_q}));

    assert_no_spill_R3: assert property (@(posedge clk) disable iff (rst)
        (load_i || step_i) |-> !spill);

    assert_done_carry_clear_R4: assert property (@(posedge clk) disable iff (rst)
        done_i |-> carry_zero_o);

    assert_result_hold_R8: assert property (@(posedge clk) disable iff (rst)
        !done_i |-> $stable(result_q));

endmodule

// File: rtl/xas_adder.sv
module xas_adder #(
    parameter int WIDTH = 4,
    localparam int CW   = $clog2(WIDTH + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic [WIDTH-1:0] addend_a,
    input  logic [WIDTH-1:0] addend_b,
    output logic [WIDTH:0]   result,
    output logic             busy,
    output logic             done,
    output logic [CW-1:0]    steps
);

    logic load, step, finish, carry_zero;

    xas_ctrl #(.N(WIDTH), .CW(CW)) u_ctrl (
        .clk          (clk),
        .rst          (rst),
        .start_i      (start),
        .carry_zero_i (carry_zero),
        .load_o       (load),
        .step_o       (step),
        .finish_o     (finish),
        .busy_o       (busy),
        .done_o       (done),
        .steps_o      (steps)
    );

    xas_datapath #(.N(WIDTH)) u_datapath (
        .clk          (clk),
        .rst          (rst),
        .load_i       (load),
        .step_i       (step),
        .finish_i     (finish),
        .done_i       (done),
        .a_i          (addend_a),
        .b_i          (addend_b),
        .carry_zero_o (carry_zero),
        .result_o     (result)
    );

endmodule

// File: tb/xas_adder_bench.sv
module xas_adder_bench;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #4 clk = ~clk;

    int checks = 0;
    int failures = 0;
    bit finished = 1'b0;

    // 4-bit instance
    logic       st4 = 1'b0;
    logic [3:0] a4 = '0, b4 = '0;
    logic [4:0] res4;
    logic       busy4, done4;
    logic [2:0] steps4;

    xas_adder #(.WIDTH(4)) u_xas_adder (
        .clk(clk), .rst(rst), .start(st4), .addend_a(a4), .addend_b(b4),
        .result(res4), .busy(busy4), .done(done4), .steps(steps4)
    );

    // 8-bit instance
    logic       st8 = 1'b0;
    logic [7:0] a8 = '0, b8 = '0;
    logic [8:0] res8;
    logic       busy8, done8;
    logic [3:0] steps8;

    xas_adder #(.WIDTH(8)) u_xas_adder_w8 (
        .clk(clk), .rst(rst), .start(st8), .addend_a(a8), .addend_b(b8),
        .result(res8), .busy(busy8), .done(done8), .steps(steps8)
    );

    // {a, b, expected sum, expected steps}
    localparam int NV = 10;
    localparam logic [28:0] VEC [NV] = '{
        {8'd0,   8'd0,   9'd0,   4'd0},
        {8'd170, 8'd85,  9'd255, 4'd0},
        {8'd255, 8'd1,   9'd256, 4'd8},
        {8'd127, 8'd1,   9'd128, 4'd7},
        {8'd15,  8'd1,   9'd16,  4'd4},
        {8'd3,   8'd1,   9'd4,   4'd2},
        {8'd255, 8'd255, 9'd510, 4'd1},
        {8'd128, 8'd128, 9'd256, 4'd1},
        {8'd1,   8'd1,   9'd2,   4'd1},
        {8'd200, 8'd100, 9'd300, 4'd2}
    };

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic run4(input logic [3:0] a, input logic [3:0] b, output int lat);
        @(negedge clk);
        st4 = 1'b1; a4 = a; b4 = b;
        @(negedge clk);
        st4 = 1'b0;
        lat = 0;
        while (!done4) begin
            @(negedge clk);
            lat++;
        end
    endtask

    task automatic run8(input logic [7:0] a, input logic [7:0] b, output int lat);
        @(negedge clk);
        st8 = 1'b1; a8 = a; b8 = b;
        @(negedge clk);
        st8 = 1'b0;
        lat = 0;
        while (!done8) begin
            @(negedge clk);
            lat++;
        end
    endtask

    task automatic summary();
        if (!finished) begin
            finished = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", checks, failures);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
        checks++;
        failures++;
        summary();
    end

    initial begin
        int lat;
        logic [8:0] held_res;
        logic [3:0] held_steps;

        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        chk(res4 == 0 && busy4 == 0 && done4 == 0 && steps4 == 0, "R1 reset 4-bit",
            {res4, busy4, done4, steps4}, 0);
        chk(res8 == 0 && busy8 == 0 && done8 == 0 && steps8 == 0, "R1 reset 8-bit",
            {res8, busy8, done8, steps8}, 0);

        // R2: busy after launch
        @(negedge clk);
        st4 = 1'b1; a4 = 4'd7; b4 = 4'd9;
        @(negedge clk);
        st4 = 1'b0;
        chk(busy4 == 1'b1, "R2 busy after start", busy4, 1);
        while (!done4) @(negedge clk);
        @(negedge clk);
        chk(done4 == 1'b0, "R4 done lasts one cycle", done4, 0);

        // R4 R5 R6 R9: exhaustive 4-bit
        for (int i = 0; i < 16; i++) begin
            for (int j = 0; j < 16; j++) begin
                run4(4'(i), 4'(j), lat);
                chk(res4 == 5'(i + j), "R4 R9 sum 4-bit", res4, i + j);
                chk(busy4 == 1'b0, "R4 busy low at done", busy4, 0);
                chk(steps4 <= 3'd4, "R5 step bound 4-bit", steps4, 4);
                chk(lat == int'(steps4) + 1, "R6 latency 4-bit", lat, int'(steps4) + 1);
                if ((i & j) == 0)
                    chk(steps4 == 0, "R5 disjoint zero steps", steps4, 0);
            end
        end

        // R5 R6 R9: table on 8-bit
        for (int v = 0; v < NV; v++) begin
            run8(VEC[v][28:21], VEC[v][20:13], lat);
            chk(res8 == VEC[v][12:4], "R4 R9 sum 8-bit", res8, VEC[v][12:4]);
            chk(steps8 == VEC[v][3:0], "R5 steps 8-bit", steps8, VEC[v][3:0]);
            chk(lat == int'(VEC[v][3:0]) + 1, "R6 latency 8-bit", lat, int'(VEC[v][3:0]) + 1);
        end

        // R8: outputs hold after done
        held_res = res8;
        held_steps = steps8;
        repeat (5) @(negedge clk);
        chk(res8 == held_res, "R8 result held idle", res8, held_res);
        chk(steps8 == held_steps, "R8 steps held idle", steps8, held_steps);

        // R7: start and addends changed while busy; R8 old result held meanwhile
        @(negedge clk);
        st8 = 1'b1; a8 = 8'd255; b8 = 8'd1;
        @(negedge clk);
        a8 = 8'd2; b8 = 8'd1;
        chk(res8 == held_res, "R8 result held during run", res8, held_res);
        @(negedge clk);
        a8 = 8'd9; b8 = 8'd4;
        @(negedge clk);
        st8 = 1'b0;
        while (!done8) @(negedge clk);
        chk(res8 == 9'd256, "R7 result unaffected", res8, 256);
        chk(steps8 == 4'd8, "R7 steps unaffected", steps8, 8);

        // R2: back-to-back launch accepted in the done cycle
        st8 = 1'b1; a8 = 8'd5; b8 = 8'd2;
        @(negedge clk);
        st8 = 1'b0;
        chk(busy8 == 1'b1, "R2 relaunch from done", busy8, 1);
        while (!done8) @(negedge clk);
        chk(res8 == 9'd7 && steps8 == 0, "R5 disjoint relaunch", res8, 7);

        // R1: reset mid-computation
        @(negedge clk);
        st4 = 1'b1; a4 = 4'd15; b4 = 4'd1;
        @(negedge clk);
        st4 = 1'b0;
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        chk(busy4 == 0 && done4 == 0 && res4 == 0 && steps4 == 0, "R1 reset mid-run",
            {res4, busy4, done4, steps4}, 0);

        summary();
    end

endmodule